// File: doc/BRIEF.md
# SM4 Four-Round Vector Unit

This block executes the vector instruction that advances SM4 encryption or decryption by four rounds on every 128-bit element group of a vector register. It takes a 32-bit instruction word and checks it. It also takes the starting element index, the vector length and the element-width code, together with the full contents of the destination register and the key register as flat arrays of 32-bit elements.

After accepting a start request, the unit captures both registers. It then processes one element group per clock, from group `vstart/4` up to group `vl/4 - 1`. In each step it chains four SM4 rounds, so every round uses the words produced by the rounds before it in the same cycle. The new four-word state replaces the group in the registered result array.

The key register supplies the round keys in one of two ways. In the vector-vector form, each group takes its own four keys. In the vector-scalar form, every group takes the four keys held in group 0. Encryption and decryption differ only in the order of the keys supplied. A bad instruction word or a failed element-group check raises a one-cycle illegal flag. A finished run raises a one-cycle done pulse.

Top module: `sm4_round4_unit`

## Requirements
- R1: A word is accepted only when all of the following hold: bits 6:0 = 1110111, bits 14:12 = 010, bits 19:15 = 10000, and bits 31:25 = 1010001 (vector-vector form) or 1010011 (vector-scalar form). Any other word gives illegal. The register-number fields in bits 11:7 and 24:20 have no effect on the result.
- R2: The element-width input must carry code 3'b010 (32-bit elements). Any other code gives illegal.
- R3: An instruction is illegal if vl is not a multiple of 4, if vstart is not a multiple of 4, or if vl exceeds the element count. On an accepted but illegal start, illegal is high for exactly the one cycle after the accepting edge, done stays low, and the result array is unchanged.
- R4: For state words X0..X3 and keys rk0..rk3, a group step computes X(n+4) = X(n) ^ T(X(n+1) ^ X(n+2) ^ X(n+3) ^ rk(n)) for n = 0..3, each round using the words just produced. Thirty-two rounds in eight steps turn plaintext 0123456789abcdeffedcba9876543210 under the key of the same value into ciphertext 681edf34d206965e86b3e94f536e4246. The same steps with the keys reversed give back the plaintext.
- R5: T substitutes each byte of its input through the SM4 S-box, then computes B ^ rol(B,2) ^ rol(B,10) ^ rol(B,18) ^ rol(B,24).
- R6: In the vector-vector form, group i uses key elements 4i..4i+3. In the vector-scalar form, every group uses key elements 0..3.
- R7: Groups vstart/4 .. vl/4-1 are processed in ascending order, one per clock. Every element outside these groups keeps the value it had in the destination input at the accepting edge.
- R8: The result array is loaded from the destination input at the accepting edge. Done is high for one cycle, directly after the edge that writes the last group. If no group is in range, done is high in the cycle after the accepting edge.
- R9: A start request while a run is in progress is ignored. During the run, the instruction, destination and key inputs are not re-read.
- R10: While reset is high, and directly after it, done and illegal are low and every result element is zero.
- R11: Element 4i+0 holds the least significant state word X0 (and rk0). The outputs X4..X7 are written to elements 4i+0..4i+3 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented instruction; taken only when idle |
| instr | input | 32 | Instruction word |
| vstart | input | CNT_W | First element index |
| vl | input | CNT_W | Vector length in elements |
| sew | input | 3 | Element-width code, 3'b010 = 32 bits |
| vd_in | input | NUM_ELEM*32 | Destination register contents (current state), element 0 in bits 31:0 |
| vs2_in | input | NUM_ELEM*32 | Key register contents, element 0 in bits 31:0 |
| result | output | NUM_ELEM*32 | Registered result array |
| done | output | 1 | One-cycle pulse after the last group is written |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
Two of the unit's functions fall in the same cycle. The first is the write of the final element group, which also ends the run and raises done. The second is a fresh start request arriving while that run is still active. The bench holds start high through whole runs and swaps in a bad instruction word, junk destination data and junk keys during them. Each clock, a behavioural model that captured the operands only at the accepting edge is compared against the ports. This catches any re-acceptance, any stray illegal pulse and any key read from the live inputs, and it confirms that done appears exactly once after the last group.

// File: rtl/sm4_unit_pkg.sv
package sm4_unit_pkg;

  localparam int WORD_W = 32;

  localparam logic [6:0] OPC_VCRYPTO = 7'b1110111;
  localparam logic [2:0] F3_OPMVV    = 3'b010;
  localparam logic [4:0] SUBOP_R4    = 5'b10000;
  localparam logic [6:0] F7_PER_GRP  = 7'b1010001;
  localparam logic [6:0] F7_GRP0     = 7'b1010011;
  localparam logic [2:0] SEW_CODE32  = 3'b010;

  typedef enum logic {
    KEY_PER_GROUP = 1'b0,
    KEY_GROUP0    = 1'b1
  } key_src_e;

  function automatic logic [WORD_W-1:0] rol32(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] lin_mix(input logic [WORD_W-1:0] b);
    return b ^ rol32(b, 2) ^ rol32(b, 10) ^ rol32(b, 18) ^ rol32(b, 24);
  endfunction

endpackage

// File: rtl/sm4_sbox.sv
module sm4_sbox (
  input  logic [7:0] a,
  output logic [7:0] y
);

  logic [127:0] row;

  always_comb begin
    case (a[7:4])
      4'h0: row = 128'hd690e9fecce13db716b614c228fb2c05;
      4'h1: row = 128'h2b679a762abe04c3aa44132649860699;
      4'h2: row = 128'h9c4250f491ef987a33540b43edcfac62;
      4'h3: row = 128'he4b31ca9c908e89580df94fa758f3fa6;
      4'h4: row = 128'h4707a7fcf37317ba83593c19e6854fa8;
      4'h5: row = 128'h686b81b27164da8bf8eb0f4b70569d35;
      4'h6: row = 128'h1e240e5e6358d1a225227c3b01217887;
      4'h7: row = 128'hd40046579fd327524c3602e7a0c4c89e;
      4'h8: row = 128'heabf8ad240c738b5a3f7f2cef96115a1;
      4'h9: row = 128'he0ae5da49b341a55ad933230f58cb1e3;
      4'ha: row = 128'h1df6e22e8266ca60c02923ab0d534e6f;
      4'hb: row = 128'hd5db3745defd8e2f03ff6a726d6c5b51;
      4'hc: row = 128'h8d1baf92bbddbc7f11d95c411f105ad8;
      4'hd: row = 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0;
      4'he: row = 128'h8969974a0c96777e65b9f109c56ec684;
      4'hf: row = 128'h18f07dec3adc4d2079ee5f3ed7cb3948;
    endcase
  end

  // column 0 sits in the top byte of each row
  assign y = row[{~a[3:0], 3'b000} +: 8];

endmodule

// File: rtl/sm4_tfunc.sv
module sm4_tfunc
  import sm4_unit_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);

  localparam int NBYTE = WORD_W / 8;

  logic [WORD_W-1:0] sub;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    sm4_sbox u_sb (
      .a (din[8*b +: 8]),
      .y (sub[8*b +: 8])
    );
  end

  assign dout = lin_mix(sub);

endmodule

// File: rtl/sm4_round4.sv
module sm4_round4
  import sm4_unit_pkg::*;
#(
  parameter int ROUNDS = 4
) (
  input  logic [ROUNDS*WORD_W-1:0] state_in,
  input  logic [ROUNDS*WORD_W-1:0] key_in,
  output logic [ROUNDS*WORD_W-1:0] state_out
);

  logic [WORD_W-1:0] w    [2*ROUNDS];
  logic [WORD_W-1:0] tin  [ROUNDS];
  logic [WORD_W-1:0] tout [ROUNDS];

  for (genvar k = 0; k < ROUNDS; k++) begin : g_load
    assign w[k] = state_in[WORD_W*k +: WORD_W];
  end

  // each round consumes the three newest words of the sliding window
  for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
    assign tin[r] = w[r+1] ^ w[r+2] ^ w[r+3] ^ key_in[WORD_W*r +: WORD_W];
    sm4_tfunc u_t (
      .din  (tin[r]),
      .dout (tout[r])
    );
    assign w[r+ROUNDS] = w[r] ^ tout[r];
    assign state_out[WORD_W*r +: WORD_W] = w[r+ROUNDS];
  end

endmodule

// File: rtl/sm4_decode.sv
module sm4_decode
  import sm4_unit_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int CNT_W    = 5,
  parameter int GRP_W    = 3
) (
  input  logic [31:0]      instr,
  input  logic [CNT_W-1:0] vstart,
  input  logic [CNT_W-1:0] vl,
  input  logic [2:0]       sew,
  output logic             legal,
  output key_src_e         key_src,
  output logic [GRP_W-1:0] first_grp,
  output logic [GRP_W-1:0] end_grp
);

  logic base_ok, form_ok, shape_ok;

  assign base_ok  = (instr[6:0] == OPC_VCRYPTO) && (instr[14:12] == F3_OPMVV) &&
                    (instr[19:15] == SUBOP_R4);
  assign form_ok  = (instr[31:25] == F7_PER_GRP) || (instr[31:25] == F7_GRP0);
  assign shape_ok = (sew == SEW_CODE32) && (vl[1:0] == 2'b00) && (vstart[1:0] == 2'b00) &&
                    (vl <= CNT_W'(NUM_ELEM));

  assign legal     = base_ok && form_ok && shape_ok;
  assign key_src   = (instr[31:25] == F7_GRP0) ? KEY_GROUP0 : KEY_PER_GROUP;
  assign first_grp = vstart[CNT_W-1:2];
  assign end_grp   = vl[CNT_W-1:2];

endmodule

// File: rtl/sm4_round4_unit.sv
module sm4_round4_unit
  import sm4_unit_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [31:0]                instr,
  input  logic [CNT_W-1:0]           vstart,
  input  logic [CNT_W-1:0]           vl,
  input  logic [2:0]                 sew,
  input  logic [NUM_ELEM*WORD_W-1:0] vd_in,
  input  logic [NUM_ELEM*WORD_W-1:0] vs2_in,
  output logic [NUM_ELEM*WORD_W-1:0] result,
  output logic                       done,
  output logic                       illegal
);

  localparam int GRP_ELEM = 4;
  localparam int GRP_BITS = GRP_ELEM * WORD_W;
  localparam int GRP_W    = CNT_W - 2;
  localparam int IDX_W    = $clog2(NUM_ELEM);

  logic              dec_legal;
  key_src_e          dec_src;
  logic [GRP_W-1:0]  dec_first, dec_end;

  logic              run_q, done_q, ill_q;
  key_src_e          src_q;
  logic [GRP_W-1:0]  grp_q, end_q;
  logic [WORD_W-1:0] res_q [NUM_ELEM];
  logic [WORD_W-1:0] key_q [NUM_ELEM];

  logic [IDX_W-1:0]    base_idx, key_base;
  logic [GRP_BITS-1:0] cur_state, cur_key, nxt_state;
  logic                accept;

  sm4_decode #(
    .NUM_ELEM (NUM_ELEM),
    .CNT_W    (CNT_W),
    .GRP_W    (GRP_W)
  ) u_dec (
    .instr     (instr),
    .vstart    (vstart),
    .vl        (vl),
    .sew       (sew),
    .legal     (dec_legal),
    .key_src   (dec_src),
    .first_grp (dec_first),
    .end_grp   (dec_end)
  );

  assign accept   = start && !run_q;
  assign base_idx = {grp_q[IDX_W-3:0], 2'b00};
  assign key_base = (src_q == KEY_GROUP0) ? '0 : base_idx;

  always_comb begin
    for (int k = 0; k < GRP_ELEM; k++) begin
      cur_state[WORD_W*k +: WORD_W] = res_q[base_idx + IDX_W'(k)];
      cur_key[WORD_W*k +: WORD_W]   = key_q[key_base + IDX_W'(k)];
    end
  end

  sm4_round4 #(.ROUNDS(GRP_ELEM)) u_rnd (
    .state_in  (cur_state),
    .key_in    (cur_key),
    .state_out (nxt_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      src_q  <= KEY_PER_GROUP;
      grp_q  <= '0;
      end_q  <= '0;
      for (int e = 0; e < NUM_ELEM; e++) begin
        res_q[e] <= '0;
        key_q[e] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (accept) begin
        if (!dec_legal) begin
          ill_q <= 1'b1;
        end else begin
          for (int e = 0; e < NUM_ELEM; e++) begin
            res_q[e] <= vd_in[WORD_W*e +: WORD_W];
            key_q[e] <= vs2_in[WORD_W*e +: WORD_W];
          end
          src_q <= dec_src;
          grp_q <= dec_first;
          end_q <= dec_end;
          if (dec_first >= dec_end) done_q <= 1'b1;
          else                      run_q  <= 1'b1;
        end
      end else if (run_q) begin
        for (int k = 0; k < GRP_ELEM; k++) begin
          res_q[base_idx + IDX_W'(k)] <= nxt_state[WORD_W*k +: WORD_W];
        end
        grp_q <= grp_q + GRP_W'(1);
        if (grp_q + GRP_W'(1) == end_q) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_out
    assign result[WORD_W*e +: WORD_W] = res_q[e];
  end

  assign done    = done_q;
  assign illegal = ill_q;

  p_illegal_from_accept_r3: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(start && !run_q));

  p_illegal_keeps_result_r3: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(result));

  p_bad_width_flagged_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !run_q && sew != SEW_CODE32) |=> illegal);

  p_done_not_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  p_done_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(run_q) || $past(start)));

  p_group_steps_r7: assert property (@(posedge clk) disable iff (rst)
    run_q |=> (!run_q || grp_q == $past(grp_q) + GRP_W'(1)));

  p_group_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (grp_q < end_q));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (run_q && start) |=> !illegal);

endmodule

// File: tb/sim_sm4_round4_unit.sv
`timescale 1ns/1ps
module sim_sm4_round4_unit;

  localparam int NE = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [31:0]       instr;
  logic [4:0]        vstart, vl;
  logic [2:0]        sew;
  logic [NE*32-1:0]  vd_in, vs2_in, result;
  logic              done, illegal;

  always #2.5 clk = ~clk;

  sm4_round4_unit #(.NUM_ELEM(NE)) u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .vstart(vstart), .vl(vl),
    .sew(sew), .vd_in(vd_in), .vs2_in(vs2_in), .result(result), .done(done),
    .illegal(illegal)
  );

  localparam logic [127:0] SBT [16] = '{
    128'hd690e9fecce13db716b614c228fb2c05, 128'h2b679a762abe04c3aa44132649860699,
    128'h9c4250f491ef987a33540b43edcfac62, 128'he4b31ca9c908e89580df94fa758f3fa6,
    128'h4707a7fcf37317ba83593c19e6854fa8, 128'h686b81b27164da8bf8eb0f4b70569d35,
    128'h1e240e5e6358d1a225227c3b01217887, 128'hd40046579fd327524c3602e7a0c4c89e,
    128'heabf8ad240c738b5a3f7f2cef96115a1, 128'he0ae5da49b341a55ad933230f58cb1e3,
    128'h1df6e22e8266ca60c02923ab0d534e6f, 128'hd5db3745defd8e2f03ff6a726d6c5b51,
    128'h8d1baf92bbddbc7f11d95c411f105ad8, 128'h0ac13188a5cd7bbd2d74d012b8e5b4b0,
    128'h8969974a0c96777e65b9f109c56ec684, 128'h18f07dec3adc4d2079ee5f3ed7cb3948};

  int          n_vec = 0;
  int          n_bad = 0;
  logic [31:0] drv_vd  [NE];
  logic [31:0] drv_key [NE];
  logic [31:0] exp_res [NE];
  logic        exp_done, exp_ill;
  logic [31:0] rk_all [32];

  function automatic logic [7:0] sb(input logic [7:0] x);
    logic [127:0] r;
    r = SBT[x / 16];
    return r[8*(15 - (x % 16)) +: 8];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(input logic [31:0] v);
    return {sb(v[31:24]), sb(v[23:16]), sb(v[15:8]), sb(v[7:0])};
  endfunction

  function automatic logic [31:0] t_enc(input logic [31:0] v);
    logic [31:0] b;
    b = tau(v);
    return b ^ rl(b, 2) ^ rl(b, 10) ^ rl(b, 18) ^ rl(b, 24);
  endfunction

  function automatic logic [31:0] t_key(input logic [31:0] v);
    logic [31:0] b;
    b = tau(v);
    return b ^ rl(b, 13) ^ rl(b, 23);
  endfunction

  function automatic logic [31:0] mk_instr(input logic [6:0] f7, input logic [4:0] rs2,
                                           input logic [4:0] rd);
    return {f7, rs2, 5'b10000, 3'b010, rd, 7'b1110111};
  endfunction

  task automatic check_cycle(input string req);
    bit bad = 0;
    n_vec++;
    if (done !== exp_done) begin
      $display("FAIL %s done actual %0b expected %0b", req, done, exp_done); bad = 1;
    end
    if (illegal !== exp_ill) begin
      $display("FAIL %s illegal actual %0b expected %0b", req, illegal, exp_ill); bad = 1;
    end
    for (int k = 0; k < NE; k++) begin
      if (result[32*k +: 32] !== exp_res[k]) begin
        $display("FAIL %s element %0d actual %h expected %h", req, k, result[32*k +: 32],
                 exp_res[k]);
        bad = 1;
      end
    end
    if (bad) n_bad++;
  endtask

  task automatic check_word(input int idx, input logic [31:0] want, input string req);
    n_vec++;
    if (result[32*idx +: 32] !== want) begin
      $display("FAIL %s known-answer element %0d actual %h expected %h", req, idx,
               result[32*idx +: 32], want);
      n_bad++;
    end
  endtask

  // model: four chained rounds over one group of exp_res
  task automatic model_group(input int g, input bit grp0);
    logic [31:0] x [8];
    logic [31:0] rk [4];
    for (int k = 0; k < 4; k++) begin
      x[k]  = exp_res[4*g + k];
      rk[k] = drv_key[(grp0 ? 0 : 4*g) + k];
    end
    for (int r = 0; r < 4; r++) x[r+4] = x[r] ^ t_enc(x[r+1] ^ x[r+2] ^ x[r+3] ^ rk[r]);
    for (int k = 0; k < 4; k++) exp_res[4*g + k] = x[k+4];
  endtask

  task automatic run_cmd(input logic [31:0] ins, input int vs, input int vln,
                         input logic [2:0] sw, input bit noise, input string req);
    bit ok, grp0;
    int g, last;
    ok = (ins[6:0] == 7'b1110111) && (ins[14:12] == 3'b010) && (ins[19:15] == 5'b10000) &&
         (ins[31:25] == 7'b1010001 || ins[31:25] == 7'b1010011) && (sw == 3'b010) &&
         (vln % 4 == 0) && (vs % 4 == 0) && (vln <= NE);
    grp0 = (ins[31:25] == 7'b1010011);
    @(negedge clk);
    instr = ins; vstart = 5'(vs); vl = 5'(vln); sew = sw;
    for (int k = 0; k < NE; k++) begin
      vd_in[32*k +: 32]  = drv_vd[k];
      vs2_in[32*k +: 32] = drv_key[k];
    end
    start = 1'b1;
    @(negedge clk);
    exp_done = 1'b0; exp_ill = 1'b0;
    if (!ok) begin
      exp_ill = 1'b1;
      check_cycle(req);
      start = 1'b0;
    end else begin
      for (int k = 0; k < NE; k++) exp_res[k] = drv_vd[k];
      g = vs / 4; last = vln / 4;
      exp_done = (g >= last);
      check_cycle(req);
      if (noise && !exp_done) begin
        instr = 32'h0; sew = 3'b111;
        vd_in = {NE{32'hdeadbeef}}; vs2_in = {NE{32'h5a5a5a5a}};
      end else start = 1'b0;
      while (g < last) begin
        model_group(g, grp0);
        g++;
        exp_done = (g == last);
        @(negedge clk);
        check_cycle(req);
        if (exp_done) start = 1'b0;
      end
    end
    @(negedge clk);
    exp_done = 1'b0; exp_ill = 1'b0;
    check_cycle(req);
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired");
    n_bad++;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] kk [36];
    logic [31:0] ck, ivv, ivs;
    logic [31:0] fk [4];
    rst = 1'b1; start = 1'b0; instr = '0; vstart = '0; vl = '0; sew = '0;
    vd_in = '0; vs2_in = '0;
    for (int k = 0; k < NE; k++) exp_res[k] = '0;
    exp_done = 1'b0; exp_ill = 1'b0;

    // key schedule for the known-answer vector
    fk = '{32'ha3b1bac6, 32'h56aa3350, 32'h677d9197, 32'hb27022dc};
    kk[0] = 32'h01234567 ^ fk[0]; kk[1] = 32'h89abcdef ^ fk[1];
    kk[2] = 32'hfedcba98 ^ fk[2]; kk[3] = 32'h76543210 ^ fk[3];
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 4; j++) ck[8*(3-j) +: 8] = 8'(((4*i + j) * 7) % 256);
      kk[i+4] = kk[i] ^ t_key(kk[i+1] ^ kk[i+2] ^ kk[i+3] ^ ck);
      rk_all[i] = kk[i+4];
    end

    repeat (3) @(negedge clk);
    check_cycle("R10 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_cycle("R10 after reset");

    ivv = mk_instr(7'b1010001, 5'd8, 5'd4);
    ivs = mk_instr(7'b1010011, 5'd8, 5'd4);

    // known-answer encryption, eight steps on group 0
    drv_vd[0] = 32'h01234567; drv_vd[1] = 32'h89abcdef;
    drv_vd[2] = 32'hfedcba98; drv_vd[3] = 32'h76543210;
    for (int k = 4; k < NE; k++) drv_vd[k] = 32'h11110000 + 32'(k);
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < NE; k++) drv_key[k] = (k < 4) ? rk_all[4*r + k] : 32'hcafe0000 + 32'(k);
      run_cmd(mk_instr(7'b1010011, 5'(r), 5'(31 - r)), 0, 4, 3'b010, r[0], "R4 R5 R11 encrypt");
      for (int k = 0; k < 4; k++) drv_vd[k] = result[32*k +: 32];
    end
    check_word(3, 32'h681edf34, "R4 R11");
    check_word(2, 32'hd206965e, "R4 R11");
    check_word(1, 32'h86b3e94f, "R4 R11");
    check_word(0, 32'h536e4246, "R5 R11");

    // decryption with reversed keys
    drv_vd[0] = 32'h681edf34; drv_vd[1] = 32'hd206965e;
    drv_vd[2] = 32'h86b3e94f; drv_vd[3] = 32'h536e4246;
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 4; k++) drv_key[k] = rk_all[31 - (4*r + k)];
      run_cmd(ivs, 0, 4, 3'b010, 1'b0, "R4 decrypt");
      for (int k = 0; k < 4; k++) drv_vd[k] = result[32*k +: 32];
    end
    check_word(3, 32'h01234567, "R4 decrypt");
    check_word(0, 32'h76543210, "R4 decrypt");

    // multi-group patterns
    for (int k = 0; k < NE; k++) begin
      drv_vd[k]  = 32'(k) * 32'h9e3779b9 ^ 32'h0f1e2d3c;
      drv_key[k] = 32'(k + 7) * 32'h85ebca6b ^ 32'h7a5b3c4d;
    end
    run_cmd(ivv, 0, 16, 3'b010, 1'b1, "R6 R9 vv full");
    run_cmd(ivs, 0, 16, 3'b010, 1'b1, "R6 R9 vs full");
    run_cmd(mk_instr(7'b1010001, 5'd31, 5'd0), 8, 16, 3'b010, 1'b0, "R7 R1 upper groups");
    run_cmd(ivs, 4, 8, 3'b010, 1'b0, "R7 middle group");
    run_cmd(ivv, 8, 8, 3'b010, 1'b0, "R8 empty range");
    run_cmd(ivv, 12, 4, 3'b010, 1'b0, "R8 start past end");

    // rejected requests: result must hold the previous run's values
    run_cmd(ivv, 0, 16, 3'b011, 1'b0, "R2 width code");
    run_cmd(ivv, 0, 6, 3'b010, 1'b0, "R3 vl unaligned");
    run_cmd(ivv, 2, 16, 3'b010, 1'b0, "R3 vstart unaligned");
    run_cmd(ivv, 0, 20, 3'b010, 1'b0, "R3 vl too long");
    run_cmd(mk_instr(7'b1010101, 5'd8, 5'd4), 0, 16, 3'b010, 1'b0, "R1 bad form");
    run_cmd(ivv ^ 32'h0000_8000, 0, 16, 3'b010, 1'b0, "R1 bad subop");
    run_cmd(ivv ^ 32'h0000_1000, 0, 16, 3'b010, 1'b0, "R1 bad funct3");
    run_cmd(ivv ^ 32'h0000_0001, 0, 16, 3'b010, 1'b0, "R1 bad opcode");
    run_cmd(ivs, 0, 8, 3'b010, 1'b1, "R6 R8 vs two groups");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule